// File: doc/BRIEF.md
# Packet Mailbox Controller

A register-mapped peripheral that passes packets between a host processor and a byte-wide network stream, one byte per host access. The host sees a 64-byte window of 32-bit registers on a simple bus with a word address, a write enable, write data, a read strobe and read data. Read data is combinational from the current address, and any side effect of a read takes place at the clock edge that ends the access.

To send, the host writes a byte count and then pushes that many bytes through a transmit data register. Each accepted byte appears on the network side, which uses valid/ready and a last-byte marker. Received packets are collected in an internal buffer. When the last byte arrives, the block publishes the length and raises a receive-available status bit. The host then pops the bytes one read at a time. Three status sources (transmit done, receive available and a software test source) are ORed onto one interrupt line.

Top module: `pkt_mailbox`

## Requirements
- R1: Word 0 (byte offset 0x00) and word 1 (0x04) read as a 64-bit identifier holding the eight characters "PKTMAIL" followed by the ASCII digit VERSION. The first character sits in bits 7:0 of word 0, and later characters occupy higher bytes.
- R2: Word 2 (0x08) reads 1 in bit 0, with all other bits 0, while a packet is partly received, or the transmit count is non-zero, or a transmitted byte is still waiting on the network side. Otherwise the word reads 0.
- R3: When the last byte of a network packet is accepted, word 3 (0x0C) becomes the number of bytes stored. Word 7 (0x1C) then returns those bytes in arrival order in bits 7:0, with bits 31:8 zero, and each such read lowers word 3 by one.
- R4: A read of word 7 while word 3 is 0 returns 0 and changes no register.
- R5: While bit 1 of word 5 (0x14, receive available) is set, netRxReady is low and no byte is taken. Writing 1 to that bit clears it and discards any unread bytes, so word 3 reads 0.
- R6: A write to word 4 (0x10) loads the transmit count, with values above MAX_LEN (65536) clamped to MAX_LEN. Word 4 reads back the number of bytes still to be pushed.
- R7: A write to word 8 (0x20) is taken only when the transmit count is non-zero and the network holding stage is empty or is handing over in the same cycle. A taken byte is presented on netTxData in the next cycle, the count drops by one, and netTxLast is high with the final byte. The data and marker stay unchanged while netTxReady is low. Writes that are not taken are ignored.
- R8: Bit 0 of word 5 (transmit done) is set in the cycle after the final byte is handed over on the network side. Writing 1 to bit 0 clears it.
- R9: Bit 31 of word 5 is the test source. A write to word 5 copies write-data bit 31 into it. A read of word 5 returns the current value and then clears the bit.
- R10: irq is high exactly when at least one of bits 0, 1 and 31 of word 5 is set.
- R11: Word 6 (0x18) reads the INT_INFO parameter. Words 8 to 15 read 0.
- R12: Bytes of a packet beyond RX_DEPTH are accepted and dropped, so word 3 reports at most RX_DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 4 | Word index inside the window (byte offset / 4) |
| hostWrEn | input | 1 | Host write enable; takes priority over a read |
| hostWrData | input | 32 | Host write data |
| hostRdEn | input | 1 | Host read strobe; triggers read side effects |
| hostRdData | output | 32 | Read data for the addressed word (combinational) |
| netRxValid | input | 1 | Receive byte valid |
| netRxData | input | 8 | Receive byte |
| netRxLast | input | 1 | Receive byte is the last of its packet |
| netRxReady | output | 1 | Block accepts a receive byte |
| netTxValid | output | 1 | Transmit byte valid |
| netTxData | output | 8 | Transmit byte |
| netTxLast | output | 1 | Transmit byte is the last of its packet |
| netTxReady | input | 1 | Network side takes the transmit byte |
| irq | output | 1 | Interrupt request |

## Verification
A read returns its value in the same cycle the strobe is presented, and its side effects (a receive pop, clearing the test bit) show from the following cycle. A pushed byte appears on the network side one cycle after the write. Transmit done and receive available both rise one cycle after the accepting network handshake, and irq and netRxReady follow those bits with no added delay. The bench drives every input one nanosecond after a rising edge and compares all outputs against a behavioural model on the falling edge. At that point each result due for the cycle has settled, and the model advances only after its comparison.

// File: rtl/pkt_mailbox_pkg.sv
package pkt_mailbox_pkg;

  // Register word index inside the 64-byte window; order follows the offsets.
  typedef enum logic [3:0] {
    SEL_ID_LO   = 4'd0,
    SEL_ID_HI   = 4'd1,
    SEL_BUSY    = 4'd2,
    SEL_RX_CNT  = 4'd3,
    SEL_TX_CNT  = 4'd4,
    SEL_INT_CTL = 4'd5,
    SEL_INT_INF = 4'd6,
    SEL_RX_DATA = 4'd7,
    SEL_TX_DATA = 4'd8,
    SEL_NONE    = 4'd15
  } regSel_t;

  // Strobes from control to datapath, all single-cycle.
  typedef struct packed {
    logic ldTxCnt;
    logic txPush;
    logic rxTake;
    logic rxEnd;
    logic rxPop;
    logic rxFlush;
  } mbxStrobe_t;

  // Status vector bit positions (compacted form of the interrupt word).
  localparam int ST_TX_DONE  = 0;
  localparam int ST_RX_AVAIL = 1;
  localparam int ST_TEST     = 2;

endpackage

// File: rtl/pkt_mailbox_ctrl.sv
module pkt_mailbox_ctrl
  import pkt_mailbox_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] hostAddr,
  input  logic       hostWrEn,
  input  logic [2:0] intWrBits,   // {wrData[31], wrData[1], wrData[0]}
  input  logic       hostRdEn,
  input  logic       netRxValid,
  input  logic       netRxLast,
  input  logic       rxCntNz,
  input  logic       txCntNz,
  input  logic       txStageFree,
  input  logic       txLastDone,
  output regSel_t    regSel,
  output mbxStrobe_t strb,
  output logic [2:0] intStat,
  output logic       netRxReady,
  output logic       irq
);

  logic rdAct;
  logic intWr;
  logic intRd;

  always_comb begin
    regSel = (hostAddr <= 4'd8) ? regSel_t'(hostAddr) : SEL_NONE;
  end

  assign rdAct = hostRdEn && !hostWrEn;
  assign intWr = hostWrEn && (regSel == SEL_INT_CTL);
  assign intRd = rdAct && (regSel == SEL_INT_CTL);

  always_comb begin
    strb.ldTxCnt = hostWrEn && (regSel == SEL_TX_CNT);
    strb.txPush  = hostWrEn && (regSel == SEL_TX_DATA) && txCntNz && txStageFree;
    strb.rxTake  = netRxValid && !intStat[ST_RX_AVAIL];
    strb.rxEnd   = netRxValid && !intStat[ST_RX_AVAIL] && netRxLast;
    strb.rxPop   = rdAct && (regSel == SEL_RX_DATA) && rxCntNz;
    strb.rxFlush = intWr && intWrBits[1];
  end

  // Status bits: a set event wins over a same-cycle clear.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      intStat <= '0;
    end else begin
      if (txLastDone)                  intStat[ST_TX_DONE] <= 1'b1;
      else if (intWr && intWrBits[0])  intStat[ST_TX_DONE] <= 1'b0;

      if (strb.rxEnd)                  intStat[ST_RX_AVAIL] <= 1'b1;
      else if (intWr && intWrBits[1])  intStat[ST_RX_AVAIL] <= 1'b0;

      if (intWr)                       intStat[ST_TEST] <= intWrBits[2];
      else if (intRd)                  intStat[ST_TEST] <= 1'b0;
    end
  end

  assign netRxReady = !intStat[ST_RX_AVAIL];
  assign irq        = |intStat;

endmodule

// File: rtl/pkt_mailbox_dp.sv
module pkt_mailbox_dp
  import pkt_mailbox_pkg::*;
#(
  parameter int          RX_DEPTH = 64,
  parameter int          MAX_LEN  = 65536,
  parameter int          VERSION  = 1,
  parameter logic [31:0] INT_INFO = 32'h0000_0001
) (
  input  logic        clk,
  input  logic        rstN,
  input  regSel_t     regSel,
  input  mbxStrobe_t  strb,
  input  logic [31:0] hostWrData,
  input  logic [2:0]  intStat,
  input  logic [7:0]  netRxData,
  input  logic        netTxReady,
  output logic [31:0] hostRdData,
  output logic        netTxValid,
  output logic [7:0]  netTxData,
  output logic        netTxLast,
  output logic        rxCntNz,
  output logic        txCntNz,
  output logic        txStageFree,
  output logic        txLastDone
);

  localparam int CNT_W  = $clog2(MAX_LEN + 1);
  localparam int PTR_W  = $clog2(RX_DEPTH);
  localparam int FILL_W = $clog2(RX_DEPTH + 1);
  // Characters stored low byte first: P K T M A I L <digit>.
  localparam logic [63:0] DEV_ID = {8'(48 + VERSION), 56'("LIAMTKP")};

  // ---------------- receive side ----------------
  logic [7:0]        rxMem [RX_DEPTH];
  logic [FILL_W-1:0] fill;
  logic [FILL_W-1:0] keptAtEnd;
  logic [PTR_W-1:0]  rdPtr;
  logic [CNT_W-1:0]  rxCnt;
  logic              room;

  assign room      = fill < FILL_W'(RX_DEPTH);
  assign keptAtEnd = room ? fill + 1'b1 : fill;

  always_ff @(posedge clk) begin
    if (strb.rxTake && room) rxMem[fill[PTR_W-1:0]] <= netRxData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fill  <= '0;
      rdPtr <= '0;
      rxCnt <= '0;
    end else begin
      if (strb.rxEnd)                fill <= '0;
      else if (strb.rxTake && room)  fill <= fill + 1'b1;

      if (strb.rxEnd)                rdPtr <= '0;
      else if (strb.rxPop)           rdPtr <= rdPtr + 1'b1;

      if (strb.rxEnd)                rxCnt <= CNT_W'(keptAtEnd);
      else if (strb.rxFlush)         rxCnt <= '0;
      else if (strb.rxPop)           rxCnt <= rxCnt - 1'b1;
    end
  end

  assign rxCntNz = rxCnt != '0;

  // ---------------- transmit side ----------------
  logic [CNT_W-1:0] txCnt;
  logic             stV;
  logic [7:0]       stD;
  logic             stL;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txCnt <= '0;
      stV   <= 1'b0;
      stD   <= '0;
      stL   <= 1'b0;
    end else begin
      if (strb.ldTxCnt)
        txCnt <= (hostWrData > 32'(MAX_LEN)) ? CNT_W'(MAX_LEN) : hostWrData[CNT_W-1:0];
      else if (strb.txPush)
        txCnt <= txCnt - 1'b1;

      if (strb.txPush) begin
        stV <= 1'b1;
        stD <= hostWrData[7:0];
        stL <= (txCnt == CNT_W'(1));
      end else if (netTxReady) begin
        stV <= 1'b0;
      end
    end
  end

  assign txCntNz     = txCnt != '0;
  assign txStageFree = !stV || netTxReady;
  assign txLastDone  = stV && netTxReady && stL;
  assign netTxValid  = stV;
  assign netTxData   = stD;
  assign netTxLast   = stL;

  // ---------------- read mux ----------------
  logic busy;
  assign busy = (fill != '0) || txCntNz || stV;

  always_comb begin
    case (regSel)
      SEL_ID_LO:   hostRdData = DEV_ID[31:0];
      SEL_ID_HI:   hostRdData = DEV_ID[63:32];
      SEL_BUSY:    hostRdData = {31'b0, busy};
      SEL_RX_CNT:  hostRdData = 32'(rxCnt);
      SEL_TX_CNT:  hostRdData = 32'(txCnt);
      SEL_INT_CTL: hostRdData = {intStat[ST_TEST], 29'b0,
                                 intStat[ST_RX_AVAIL], intStat[ST_TX_DONE]};
      SEL_INT_INF: hostRdData = INT_INFO;
      SEL_RX_DATA: hostRdData = rxCntNz ? {24'b0, rxMem[rdPtr]} : 32'b0;
      default:     hostRdData = 32'b0;
    endcase
  end

endmodule

// File: rtl/pkt_mailbox.sv
module pkt_mailbox
  import pkt_mailbox_pkg::*;
#(
  parameter int          RX_DEPTH = 64,
  parameter int          MAX_LEN  = 65536,
  parameter int          VERSION  = 1,
  parameter logic [31:0] INT_INFO = 32'h0000_0001
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  hostAddr,
  input  logic        hostWrEn,
  input  logic [31:0] hostWrData,
  input  logic        hostRdEn,
  output logic [31:0] hostRdData,
  input  logic        netRxValid,
  input  logic [7:0]  netRxData,
  input  logic        netRxLast,
  output logic        netRxReady,
  output logic        netTxValid,
  output logic [7:0]  netTxData,
  output logic        netTxLast,
  input  logic        netTxReady,
  output logic        irq
);

  regSel_t    regSel;
  mbxStrobe_t strb;
  logic [2:0] intStat;
  logic       rxCntNz;
  logic       txCntNz;
  logic       txStageFree;
  logic       txLastDone;

  pkt_mailbox_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .hostAddr    (hostAddr),
    .hostWrEn    (hostWrEn),
    .intWrBits   ({hostWrData[31], hostWrData[1:0]}),
    .hostRdEn    (hostRdEn),
    .netRxValid  (netRxValid),
    .netRxLast   (netRxLast),
    .rxCntNz     (rxCntNz),
    .txCntNz     (txCntNz),
    .txStageFree (txStageFree),
    .txLastDone  (txLastDone),
    .regSel      (regSel),
    .strb        (strb),
    .intStat     (intStat),
    .netRxReady  (netRxReady),
    .irq         (irq)
  );

  pkt_mailbox_dp #(
    .RX_DEPTH (RX_DEPTH),
    .MAX_LEN  (MAX_LEN),
    .VERSION  (VERSION),
    .INT_INFO (INT_INFO)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .regSel      (regSel),
    .strb        (strb),
    .hostWrData  (hostWrData),
    .intStat     (intStat),
    .netRxData   (netRxData),
    .netTxReady  (netTxReady),
    .hostRdData  (hostRdData),
    .netTxValid  (netTxValid),
    .netTxData   (netTxData),
    .netTxLast   (netTxLast),
    .rxCntNz     (rxCntNz),
    .txCntNz     (txCntNz),
    .txStageFree (txStageFree),
    .txLastDone  (txLastDone)
  );

endmodule

// File: rtl/pkt_mailbox_chk.sv
module pkt_mailbox_chk (
  input logic        clk,
  input logic        rstN,
  input logic [3:0]  hostAddr,
  input logic        hostWrEn,
  input logic        wrTestBit,
  input logic        hostRdEn,
  input logic [31:0] hostRdData,
  input logic        netRxValid,
  input logic        netRxLast,
  input logic        netRxReady,
  input logic        netTxValid,
  input logic [7:0]  netTxData,
  input logic        netTxLast,
  input logic        netTxReady,
  input logic        irq,
  input logic        txDoneBit,
  input logic        testBit,
  input logic        rxCntNz
);

  assert_rx_empty_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdEn && !hostWrEn && hostAddr == 4'd7 && !rxCntNz) |-> hostRdData == 32'b0);

  assert_rx_block_R5: assert property (@(posedge clk) disable iff (!rstN)
    (netRxValid && netRxReady && netRxLast) |=> !netRxReady);

  assert_tx_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (netTxValid && !netTxReady) |=> netTxValid && $stable(netTxData) && $stable(netTxLast));

  assert_txdone_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txDoneBit) |-> $past(netTxValid && netTxReady && netTxLast));

  assert_test_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostAddr == 4'd5 && wrTestBit) |=> irq);

  assert_test_rdclr_R9: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdEn && !hostWrEn && hostAddr == 4'd5) |=> !testBit);

endmodule

bind pkt_mailbox pkt_mailbox_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .hostAddr   (hostAddr),
  .hostWrEn   (hostWrEn),
  .wrTestBit  (hostWrData[31]),
  .hostRdEn   (hostRdEn),
  .hostRdData (hostRdData),
  .netRxValid (netRxValid),
  .netRxLast  (netRxLast),
  .netRxReady (netRxReady),
  .netTxValid (netTxValid),
  .netTxData  (netTxData),
  .netTxLast  (netTxLast),
  .netTxReady (netTxReady),
  .irq        (irq),
  .txDoneBit  (intStat[0]),
  .testBit    (intStat[2]),
  .rxCntNz    (rxCntNz)
);

// File: tb/pkt_mailbox_tb.sv
module pkt_mailbox_tb;

  localparam int          RX_DEPTH = 64;
  localparam int          MAX_LEN  = 65536;
  localparam logic [31:0] INT_INFO = 32'h0000_0001;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  hostAddr = '0;
  logic        hostWrEn = 1'b0;
  logic [31:0] hostWrData = '0;
  logic        hostRdEn = 1'b0;
  logic [31:0] hostRdData;
  logic        netRxValid = 1'b0;
  logic [7:0]  netRxData = '0;
  logic        netRxLast = 1'b0;
  logic        netRxReady;
  logic        netTxValid;
  logic [7:0]  netTxData;
  logic        netTxLast;
  logic        netTxReady = 1'b1;
  logic        irq;

  always #4 clk = ~clk;   // 125 MHz

  pkt_mailbox #(.RX_DEPTH(RX_DEPTH), .MAX_LEN(MAX_LEN), .VERSION(1), .INT_INFO(INT_INFO)) u_dut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdEn(hostRdEn), .hostRdData(hostRdData),
    .netRxValid(netRxValid), .netRxData(netRxData), .netRxLast(netRxLast),
    .netRxReady(netRxReady), .netTxValid(netTxValid), .netTxData(netTxData),
    .netTxLast(netTxLast), .netTxReady(netTxReady), .irq(irq)
  );

  int errCnt = 0;
  int chkCnt = 0;
  bit finished = 1'b0;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit        mTest, mRxAvail, mTxDone;
  logic [7:0] mRxQ[$];
  logic [7:0] mPend[$];
  int        mPendCnt;
  int        mTxCnt;
  bit        mStV, mStL;
  logic [7:0] mStD;
  string     idStr = "PKTMAIL1";

  function automatic logic [31:0] idWord(int base);
    logic [31:0] w = '0;
    for (int i = 0; i < 4; i++) w[8*i +: 8] = idStr.getc(base + i);
    return w;
  endfunction

  function automatic logic [31:0] expRead(int idx);
    case (idx)
      0: return idWord(0);
      1: return idWord(4);
      2: return {31'b0, (mPendCnt > 0) || (mTxCnt > 0) || mStV};
      3: return 32'(mRxQ.size());
      4: return 32'(mTxCnt);
      5: return {mTest, 29'b0, mRxAvail, mTxDone};
      6: return INT_INFO;
      7: return (mRxQ.size() > 0) ? {24'b0, mRxQ[0]} : 32'b0;
      default: return 32'b0;
    endcase
  endfunction

  function automatic string reqOf(int idx);
    case (idx)
      0, 1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R6";
      5: return "R9";
      7: return (mRxQ.size() > 0) ? "R3" : "R4";
      default: return "R11";
    endcase
  endfunction

  bit wrC, rdC, handoff, push, take;
  int aIdx;

  always @(negedge clk) begin
    if (!rstN) begin
      mTest = 0; mRxAvail = 0; mTxDone = 0;
      mRxQ.delete(); mPend.delete(); mPendCnt = 0;
      mTxCnt = 0; mStV = 0; mStL = 0; mStD = '0;
    end else begin
      // compare outputs with the model state
      check(irq == (mTest | mRxAvail | mTxDone), "R10", "irq", irq, mTest | mRxAvail | mTxDone);
      check(netRxReady == !mRxAvail, "R5", "netRxReady", netRxReady, !mRxAvail);
      check(netTxValid == mStV, "R7", "netTxValid", netTxValid, mStV);
      if (mStV) begin
        check(netTxData == mStD, "R7", "netTxData", netTxData, mStD);
        check(netTxLast == mStL, "R7", "netTxLast", netTxLast, mStL);
      end
      aIdx = hostAddr;
      wrC  = hostWrEn;
      rdC  = hostRdEn && !hostWrEn;
      if (rdC) check(hostRdData === expRead(aIdx), reqOf(aIdx), "read data", hostRdData, expRead(aIdx));

      // advance the model across the coming rising edge
      handoff = mStV && netTxReady;
      push    = wrC && aIdx == 8 && mTxCnt > 0 && (!mStV || netTxReady);
      take    = netRxValid && !mRxAvail;

      if (handoff && mStL) mTxDone = 1;
      else if (wrC && aIdx == 5 && hostWrData[0]) mTxDone = 0;

      if (push) begin
        mStV = 1; mStD = hostWrData[7:0]; mStL = (mTxCnt == 1);
      end else if (handoff) mStV = 0;

      if (wrC && aIdx == 4) mTxCnt = (hostWrData > 32'(MAX_LEN)) ? MAX_LEN : int'(hostWrData);
      else if (push) mTxCnt--;

      if (rdC && aIdx == 7 && mRxQ.size() > 0) void'(mRxQ.pop_front());
      if (wrC && aIdx == 5 && hostWrData[1]) begin mRxAvail = 0; mRxQ.delete(); end
      if (take) begin
        if (mPendCnt < RX_DEPTH) mPend.push_back(netRxData);
        mPendCnt++;
        if (netRxLast) begin
          mRxQ = mPend; mPend.delete(); mPendCnt = 0; mRxAvail = 1;
        end
      end

      if (wrC && aIdx == 5) mTest = hostWrData[31];
      else if (rdC && aIdx == 5) mTest = 0;
    end
  end

  // ---------------- stimulus tasks (drive 1 ns after the rising edge) ----------------
  task automatic wr(int a, logic [31:0] d);
    hostAddr = 4'(a); hostWrData = d; hostWrEn = 1'b1;
    @(posedge clk); #1;
    hostWrEn = 1'b0;
  endtask

  task automatic rd(int a);
    hostAddr = 4'(a); hostRdEn = 1'b1;
    @(posedge clk); #1;
    hostRdEn = 1'b0;
  endtask

  task automatic rxb(logic [7:0] d, bit last);
    netRxValid = 1'b1; netRxData = d; netRxLast = last;
    @(posedge clk); #1;
    netRxValid = 1'b0; netRxLast = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    chkCnt++; errCnt++;
    $display("FAIL R7 watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // reset state at the ports
    check(irq == 1'b0, "R10", "reset irq", irq, 0);
    check(netRxReady == 1'b1, "R5", "reset netRxReady", netRxReady, 1);
    check(netTxValid == 1'b0, "R7", "reset netTxValid", netTxValid, 0);
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    idle(1);

    // R1 R2 R11: every word of the window after reset
    for (int i = 0; i < 16; i++) rd(i);

    // R3: five-byte packet, then reads in order with decrement
    for (int i = 0; i < 5; i++) rxb(8'hA0 + 8'(i), i == 4);
    rxb(8'hEE, 1'b1);            // R5: refused while receive-available is set
    rd(3);
    for (int i = 0; i < 5; i++) rd(7);
    rd(7);                       // R4: empty read
    rd(3);
    rd(5);
    wr(5, 32'h2);                // R5: clear receive-available
    rd(5);

    // R2: busy during a partial receive
    rxb(8'h11, 1'b0);
    rxb(8'h12, 1'b0);
    rd(2);
    rxb(8'h13, 1'b1);
    rd(2);
    rd(7);
    wr(5, 32'h2);

    // R12: oversized packet, then R5 flush with unread bytes
    for (int i = 0; i < 70; i++) rxb(8'h10 + 8'(i), i == 69);
    rd(3);
    for (int i = 0; i < 3; i++) rd(7);
    wr(5, 32'h2);
    rd(3);
    rd(7);

    // R6 R7 R8: three bytes back to back, a fourth write ignored
    wr(4, 32'd3);
    rd(4);
    rd(2);
    wr(8, 32'hFFFF_FF31);
    wr(8, 32'h32);
    wr(8, 32'h33);
    wr(8, 32'h34);
    rd(4);
    idle(1);
    rd(5);
    wr(5, 32'h1);
    rd(5);

    // R7: back-pressure from the network side
    wr(4, 32'd2);
    netTxReady = 1'b0;
    wr(8, 32'hA1);
    wr(8, 32'hA2);               // stage busy: ignored
    rd(2);
    idle(2);
    netTxReady = 1'b1;
    idle(1);
    wr(8, 32'hA3);
    idle(2);
    rd(4);
    wr(5, 32'h1);

    // R6: clamp at the length limit, then clear
    wr(4, 32'h0002_0000);
    rd(4);
    wr(4, 32'd65535);
    rd(4);
    wr(4, 32'd0);
    rd(4);
    rd(2);

    // R9 R10: test source
    wr(5, 32'h8000_0000);
    rd(5);
    rd(5);
    wr(5, 32'h8000_0000);
    idle(1);
    wr(5, 32'h0);
    rd(5);

    idle(3);
    finish_run();
  end

endmodule